// File: doc/BRIEF.md
# Binary/Decimal Add-Subtract ALU

This block is an 8-bit arithmetic unit that adds with carry and subtracts with borrow, in either plain binary or packed BCD. A decimal-mode input selects BCD. The same subtract datapath also serves a compare operation. A compare reports flags only and returns the first operand unchanged as its result. Register files and instruction sequencing are not part of this block. The surrounding datapath feeds it one operation at a time and reads back an 8-bit result with zero, negative, carry and overflow flags.

Operations enter on a valid/ready input stream. Results leave on a valid/ready output stream through a single output register. A new operation is accepted when `in_valid` and `in_ready` are both high at a rising clock edge. `in_ready` is high whenever the output register is empty or its content is being taken in the same cycle. While `out_valid` is high and `out_ready` is low, the output is held and no new operation is taken. The block therefore sustains one operation per cycle under continuous consumption, and stalls cleanly under back-pressure.

In decimal addition the zero flag follows the uncorrected binary sum, not the adjusted decimal result. The negative flag is taken before the upper-digit correction.

Top module: `bcd_addsub_alu`

## Requirements
- R1: An operation is taken when in_valid and in_ready are high at a clock edge, and its result appears one cycle later with out_valid high. in_ready equals (not out_valid) or out_ready. While out_valid is high and out_ready is low, out_valid and all outputs stay unchanged. After reset out_valid is low.
- R2: Binary add (in_op 2'b00, in_decimal 0) gives result (A+B+C) mod 256. Carry is set when the 9-bit sum exceeds 0xFF. Overflow is set when A and B have the same bit 7 and the result's bit 7 differs from it. Zero means the result is 0, and negative is result bit 7.
- R3: Binary subtract (in_op 2'b01, in_decimal 0) gives result (A-B-(1-C)) mod 256. Carry is set when no borrow occurs. Overflow is bit 7 of (A^B)&(A^result). Zero and negative come from the result.
- R4: Decimal add computes the low digits plus carry-in. If that value is 10 or more, it is replaced by ((value+6) mod 16) + 0x10. The high digits of A and B (each masked with 0xF0) are then added to it. If the total is 0xA0 or more, 0x60 is added. Carry is set when the final total exceeds 0xFF, and the result is its low 8 bits.
- R5: Decimal add sets zero when (A+B+C) mod 256 is 0. Negative is bit 7 of the total before the 0x60 correction.
- R6: Decimal add sets overflow when the following value lies outside -128..127: (A&0xF0) read as a signed byte, plus (B&0xF0) read as a signed byte, plus the adjusted low part.
- R7: Decimal subtract forms d = (A&0x0F)-(B&0x0F)+C-1. If d is negative, it becomes ((d-6) mod 16)-16. The result is (A&0xF0)-(B&0xF0)+d, reduced mod 256. If bit 7 of that result is set, 0x60 is subtracted (mod 256).
- R8: Decimal subtract reports zero, negative, carry and overflow exactly as binary subtract (R3) would for the same A, B and C.
- R9: Compare returns A as the result. Zero is set when A equals B. Negative is bit 7 of (A-B) mod 256. Carry is set when A >= B unsigned. Overflow is 0. Carry-in and the decimal input have no effect on a compare.
- R10: in_op 2'b10 and 2'b11 both select compare, and they behave identically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 8 | First operand (accumulator value) |
| in_b | input | 8 | Second operand |
| in_carry | input | 1 | Carry-in (for subtract: 1 means no borrow) |
| in_decimal | input | 1 | 1 selects packed BCD arithmetic |
| in_op | input | 2 | 00 add, 01 subtract, 10/11 compare |
| out_valid | output | 1 | Result register holds an unread result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_result | output | 8 | Result byte |
| out_zero | output | 1 | Zero flag |
| out_neg | output | 1 | Negative flag |
| out_carry | output | 1 | Carry flag |
| out_ovf | output | 1 | Overflow flag |

## Verification
The two functions that can land in the same cycle are the hand-off of a held result and the acceptance of the next operation. This happens when out_valid, out_ready and in_valid are all high at one edge. The bench provokes it by driving both stream sides with independent random valid and ready patterns over thousands of cycles. A behavioural reference computes each accepted operation's expected result into a queue, and every output hand-off is compared against the queue head. A dropped, duplicated or overwritten result therefore shows up as a mismatch. Stalled cycles are separately checked for a frozen output.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
  localparam int DIGIT_W = 4;
  localparam int DIGITS  = 2;
  localparam int DATA_W  = DIGIT_W * DIGITS;
  localparam int HIGH_W  = DATA_W - DIGIT_W;

  // decimal correction constants
  localparam logic [DIGIT_W:0]   LO_LIMIT  = 5'd10;
  localparam logic [DIGIT_W-1:0] LO_ADJ    = 4'd6;
  localparam logic [DATA_W-1:0]  LO_BORROW = 8'h10;
  localparam logic [DATA_W:0]    HI_LIMIT  = 9'h0A0;
  localparam logic [DATA_W+1:0]  HI_ADJ_W  = 10'h060;
  localparam logic [DATA_W-1:0]  HI_ADJ    = 8'h60;

  typedef enum logic [1:0] {
    OP_ADD     = 2'b00,
    OP_SUB     = 2'b01,
    OP_CMP     = 2'b10,
    OP_CMP_ALT = 2'b11
  } alu_op_e;

  typedef struct packed {
    logic ovf;
    logic carry;
    logic neg;
    logic zero;
  } alu_flags_t;
endpackage

// File: rtl/bcd_alu_bin.sv
module bcd_alu_bin
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  input  logic              sub,
  output logic [DATA_W-1:0] res,
  output logic              co,
  output logic              ovf
);
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W:0]   sum;

  always_comb begin
    b_eff = sub ? ~b : b;
    sum   = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, cin};
    res   = sum[DATA_W-1:0];
    co    = sum[DATA_W];
    ovf   = (a[DATA_W-1] == b_eff[DATA_W-1]) && (res[DATA_W-1] != a[DATA_W-1]);
  end
endmodule

// File: rtl/bcd_alu_dadd.sv
module bcd_alu_dadd
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              neg,
  output logic              co,
  output logic              ovf
);
  logic [DIGIT_W:0]   lo_raw;
  logic [DIGIT_W-1:0] lo_fix;
  logic [DIGIT_W:0]   lo_adj;
  logic [DATA_W:0]    hi_sum;
  logic [DATA_W+1:0]  total;
  logic [DATA_W+1:0]  ssum;

  always_comb begin
    lo_raw = {1'b0, a[DIGIT_W-1:0]} + {1'b0, b[DIGIT_W-1:0]} + {{DIGIT_W{1'b0}}, cin};
    lo_fix = lo_raw[DIGIT_W-1:0] + LO_ADJ;
    lo_adj = (lo_raw >= LO_LIMIT) ? {1'b1, lo_fix} : lo_raw;

    hi_sum = {1'b0, a[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           + {1'b0, b[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           + {{HIGH_W{1'b0}}, lo_adj};
    neg    = hi_sum[DATA_W-1];

    total  = (hi_sum >= HI_LIMIT) ? ({1'b0, hi_sum} + HI_ADJ_W) : {1'b0, hi_sum};
    co     = |total[DATA_W+1:DATA_W];
    res    = total[DATA_W-1:0];

    // signed view of the high digits plus the adjusted low part
    ssum   = {{2{a[DATA_W-1]}}, a[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           + {{2{b[DATA_W-1]}}, b[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           + {{(HIGH_W+1){1'b0}}, lo_adj};
    ovf    = !((ssum[DATA_W+1:DATA_W-1] == 3'b000) || (ssum[DATA_W+1:DATA_W-1] == 3'b111));
  end
endmodule

// File: rtl/bcd_alu_dsub.sv
module bcd_alu_dsub
  import bcd_alu_pkg::*;
(
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              cin,
  output logic [DATA_W-1:0] res
);
  logic [DATA_W-1:0] lo;
  logic [DATA_W-1:0] lo_m6;
  logic [DATA_W-1:0] lo_adj;
  logic [DATA_W-1:0] mid;

  always_comb begin
    lo     = {{HIGH_W{1'b0}}, a[DIGIT_W-1:0]}
           - {{HIGH_W{1'b0}}, b[DIGIT_W-1:0]}
           - {{(DATA_W-1){1'b0}}, ~cin};
    lo_m6  = lo - {{HIGH_W{1'b0}}, LO_ADJ};
    lo_adj = lo[DATA_W-1] ? ({{HIGH_W{1'b0}}, lo_m6[DIGIT_W-1:0]} - LO_BORROW) : lo;
    mid    = {a[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           - {b[DATA_W-1:DIGIT_W], {DIGIT_W{1'b0}}}
           + lo_adj;
    res    = mid[DATA_W-1] ? (mid - HI_ADJ) : mid;
  end
endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu
  import bcd_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic              in_carry,
  input  logic              in_decimal,
  input  logic [1:0]        in_op,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_zero,
  output logic              out_neg,
  output logic              out_carry,
  output logic              out_ovf
);
  alu_op_e           op;
  logic              is_add, is_cmp;
  logic              bin_cin;
  logic [DATA_W-1:0] bin_res;
  logic              bin_co, bin_ovf;
  logic [DATA_W-1:0] dadd_res;
  logic              dadd_neg, dadd_co, dadd_ovf;
  logic [DATA_W-1:0] dsub_res;
  logic [DATA_W-1:0] nxt_res;
  alu_flags_t        nxt_flags;
  alu_flags_t        flags_q;
  logic [DATA_W-1:0] res_q;
  logic              valid_q;
  logic              take;

  assign op      = alu_op_e'(in_op);
  assign is_add  = (op == OP_ADD);
  assign is_cmp  = (op == OP_CMP) || (op == OP_CMP_ALT);
  assign bin_cin = is_cmp ? 1'b1 : in_carry;

  // one shared binary adder: add, subtract, compare, and decimal flag source
  bcd_alu_bin u_bin (
    .a   (in_a),
    .b   (in_b),
    .cin (bin_cin),
    .sub (!is_add),
    .res (bin_res),
    .co  (bin_co),
    .ovf (bin_ovf)
  );

  bcd_alu_dadd u_dadd (
    .a   (in_a),
    .b   (in_b),
    .cin (in_carry),
    .res (dadd_res),
    .neg (dadd_neg),
    .co  (dadd_co),
    .ovf (dadd_ovf)
  );

  bcd_alu_dsub u_dsub (
    .a   (in_a),
    .b   (in_b),
    .cin (in_carry),
    .res (dsub_res)
  );

  always_comb begin
    nxt_res         = bin_res;
    nxt_flags.zero  = (bin_res == '0);
    nxt_flags.neg   = bin_res[DATA_W-1];
    nxt_flags.carry = bin_co;
    nxt_flags.ovf   = bin_ovf;
    if (is_cmp) begin
      nxt_res       = in_a;
      nxt_flags.ovf = 1'b0;
    end else if (in_decimal && is_add) begin
      nxt_res         = dadd_res;
      nxt_flags.neg   = dadd_neg;
      nxt_flags.carry = dadd_co;
      nxt_flags.ovf   = dadd_ovf;
    end else if (in_decimal) begin
      nxt_res = dsub_res;
    end
  end

  assign in_ready = !valid_q || out_ready;
  assign take     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else begin
      if (take) begin
        valid_q <= 1'b1;
        res_q   <= nxt_res;
        flags_q <= nxt_flags;
      end else if (out_ready) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid  = valid_q;
  assign out_result = res_q;
  assign out_zero   = flags_q.zero;
  assign out_neg    = flags_q.neg;
  assign out_carry  = flags_q.carry;
  assign out_ovf    = flags_q.ovf;
endmodule

// File: rtl/bcd_addsub_alu_chk.sv
module bcd_addsub_alu_chk
  import bcd_alu_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [DATA_W-1:0] in_a,
  input logic [DATA_W-1:0] in_b,
  input logic              in_carry,
  input logic              in_decimal,
  input logic [1:0]        in_op,
  input logic              out_valid,
  input logic              out_ready,
  input logic [DATA_W-1:0] out_result,
  input logic              out_zero,
  input logic              out_neg,
  input logic              out_carry,
  input logic              out_ovf
);
  // R1: a stalled result stays put
  a_r1_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable({out_zero, out_neg, out_carry, out_ovf}));

  // R1: empty output register never refuses input
  a_r1_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R1: accepted operation shows up next cycle
  a_r1_accept_gives_valid: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R2: binary add zero/negative follow the stored result
  a_r2_add_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'b00 && !in_decimal |=>
      out_zero == (out_result == '0) && out_neg == out_result[DATA_W-1]);

  // R3: binary subtract zero/negative follow the stored result
  a_r3_sub_zero_neg: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'b01 && !in_decimal |=>
      out_zero == (out_result == '0) && out_neg == out_result[DATA_W-1]);

  // R5: decimal add zero comes from the plain binary sum
  a_r5_dec_zero_binary: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 2'b00 && in_decimal |=>
      out_zero == (8'($past(in_a) + $past(in_b) + {7'd0, $past(in_carry)}) == 8'd0));

  // R9 / R10: compare returns the first operand, unsigned carry, no overflow
  a_r9_cmp_keeps_a: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op[1] |=>
      out_result == $past(in_a) && out_carry == ($past(in_a) >= $past(in_b)) &&
      !out_ovf && out_zero == ($past(in_a) == $past(in_b)));
endmodule

bind bcd_addsub_alu bcd_addsub_alu_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_a       (in_a),
  .in_b       (in_b),
  .in_carry   (in_carry),
  .in_decimal (in_decimal),
  .in_op      (in_op),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_result (out_result),
  .out_zero   (out_zero),
  .out_neg    (out_neg),
  .out_carry  (out_carry),
  .out_ovf    (out_ovf)
);

// File: tb/bcd_addsub_alu_test.sv
module bcd_addsub_alu_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_a, in_b;
  logic       in_carry, in_decimal;
  logic [1:0] in_op;
  logic       out_valid, out_ready;
  logic [7:0] out_result;
  logic       out_zero, out_neg, out_carry, out_ovf;

  int errors = 0;
  int checks = 0;
  int q_exp[$];
  int q_mode[$];
  bit hold_pending = 0;
  int hold_val;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  bcd_addsub_alu uut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_carry(in_carry),
    .in_decimal(in_decimal), .in_op(in_op),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_result(out_result), .out_zero(out_zero), .out_neg(out_neg),
    .out_carry(out_carry), .out_ovf(out_ovf)
  );

  function automatic int sx8(int x);
    return (x >= 128) ? x - 256 : x;
  endfunction

  // packed: result | zero<<8 | neg<<9 | carry<<10 | ovf<<11
  function automatic int ref_model(int a, int b, int c, int d, int op);
    int s, r, lo, sa, z, n, cy, v;
    if (op >= 2) begin
      s = a - b; r = a;
      z = ((s & 255) == 0); n = ((s & 128) != 0); cy = (a >= b); v = 0;
    end else if (op == 0 && d == 0) begin
      s = a + b + c; r = s & 255;
      z = (r == 0); n = ((r & 128) != 0); cy = (s > 255);
      v = (((~(a ^ b)) & (a ^ r) & 128) != 0);
    end else if (op == 0) begin
      lo = (a & 15) + (b & 15) + c;
      if (lo >= 10) lo = ((lo + 6) & 15) + 16;
      s  = (a & 240) + (b & 240) + lo;
      sa = sx8(a & 240) + sx8(b & 240) + lo;
      z  = (((a + b + c) & 255) == 0);
      n  = ((s & 128) != 0);
      if (s >= 160) s = s + 96;
      cy = (s > 255);
      v  = (sa < -128) || (sa > 127);
      r  = s & 255;
    end else begin
      s = a - b - (1 - c); r = s & 255;
      z = (r == 0); n = ((r & 128) != 0); cy = (s >= 0);
      v = (((a ^ b) & (a ^ r) & 128) != 0);
      if (d != 0) begin
        lo = (a & 15) - (b & 15) + c - 1;
        if (lo < 0) lo = ((lo - 6) & 15) - 16;
        s = (a & 240) - (b & 240) + lo;
        if ((s & 128) != 0) s = s - 96;
        r = s & 255;
      end
    end
    return r | (z << 8) | (n << 9) | (cy << 10) | (v << 11);
  endfunction

  // mode: 0 bin add, 1 bin sub, 2 dec add, 3 dec sub, 4 cmp 10, 5 cmp 11
  function automatic string tag_res(int m);
    case (m) 0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R7";
             4: return "R9"; default: return "R10"; endcase
  endfunction
  function automatic string tag_zn(int m);
    case (m) 0: return "R2"; 1: return "R3"; 2: return "R5"; 3: return "R8";
             4: return "R9"; default: return "R10"; endcase
  endfunction
  function automatic string tag_c(int m);
    case (m) 0: return "R2"; 1: return "R3"; 2: return "R4"; 3: return "R8";
             4: return "R9"; default: return "R10"; endcase
  endfunction
  function automatic string tag_v(int m);
    case (m) 0: return "R2"; 1: return "R3"; 2: return "R6"; 3: return "R8";
             4: return "R9"; default: return "R10"; endcase
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic observe();
    int got, e, m;
    got = {20'd0, out_ovf, out_carry, out_neg, out_zero, out_result};
    if (hold_pending) begin
      check("R1", "held output under back-pressure", out_valid ? got : -1, hold_val);
      hold_pending = 0;
    end
    check("R1", "out_valid tracks pending results", int'(out_valid), int'(q_exp.size() > 0));
    check("R1", "in_ready rule", int'(in_ready), int'(!out_valid || out_ready));
    if (out_valid && out_ready && q_exp.size() > 0) begin
      e = q_exp.pop_front();
      m = q_mode.pop_front();
      check(tag_res(m), "result", got & 255, e & 255);
      check(tag_zn(m), "zero/negative", (got >> 8) & 3, (e >> 8) & 3);
      check(tag_c(m), "carry", (got >> 10) & 1, (e >> 10) & 1);
      check(tag_v(m), "overflow", (got >> 11) & 1, (e >> 11) & 1);
    end
    if (out_valid && !out_ready) begin
      hold_pending = 1;
      hold_val = got;
    end
    if (in_valid && in_ready) begin
      q_exp.push_back(ref_model(int'(in_a), int'(in_b), int'(in_carry),
                                int'(in_decimal), int'(in_op)));
      if (in_op[1]) q_mode.push_back(in_op[0] ? 5 : 4);
      else q_mode.push_back(int'(in_op[0]) + (in_decimal ? 2 : 0));
    end
  endtask

  task automatic step(input logic v, input logic [7:0] a, input logic [7:0] b,
                      input logic c, input logic d, input logic [1:0] op,
                      input logic rdy, output bit accepted);
    @(negedge clk);
    in_valid = v; in_a = a; in_b = b; in_carry = c;
    in_decimal = d; in_op = op; out_ready = rdy;
    #1;
    accepted = v && in_ready;
    observe();
  endtask

  task automatic send(input logic [7:0] a, input logic [7:0] b, input logic c,
                      input logic d, input logic [1:0] op);
    bit acc;
    acc = 0;
    while (!acc) step(1'b1, a, b, c, d, op, ($urandom_range(0, 3) != 0), acc);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    bit acc;
    rst_n = 1'b0; in_valid = 0; in_a = 0; in_b = 0; in_carry = 0;
    in_decimal = 0; in_op = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    check("R1", "out_valid after reset", int'(out_valid), 0);
    check("R1", "in_ready after reset", int'(in_ready), 1);
    rst_n = 1'b1;

    // directed corner cases
    send(8'h7F, 8'h01, 0, 0, 2'b00);  // R2 signed overflow
    send(8'hFF, 8'h00, 1, 0, 2'b00);  // R2 carry, zero
    send(8'h80, 8'h80, 0, 0, 2'b00);  // R2 overflow with carry
    send(8'h00, 8'h01, 1, 0, 2'b01);  // R3 borrow
    send(8'h80, 8'h01, 1, 0, 2'b01);  // R3 overflow
    send(8'h50, 8'h50, 0, 0, 2'b01);  // R3 borrow from carry-in 0
    send(8'h58, 8'h46, 1, 1, 2'b00);  // R4 decimal 105
    send(8'h99, 8'h01, 0, 1, 2'b00);  // R4 R5 decimal wrap: zero from binary sum
    send(8'h80, 8'h80, 0, 1, 2'b00);  // R5 binary sum zero
    send(8'h79, 8'h00, 1, 1, 2'b00);  // R6 decimal overflow
    send(8'h00, 8'h01, 1, 1, 2'b01);  // R7 R8 decimal 00-01
    send(8'h46, 8'h12, 1, 1, 2'b01);  // R7 plain digits
    send(8'h10, 8'h01, 1, 1, 2'b01);  // R7 low-digit borrow
    send(8'h42, 8'h42, 0, 1, 2'b10);  // R9 equal, carry-in/decimal ignored
    send(8'h10, 8'h20, 1, 0, 2'b10);  // R9 less than
    send(8'hF0, 8'h01, 0, 1, 2'b11);  // R10 alternate compare code
    send(8'h42, 8'h42, 1, 0, 2'b11);  // R10 equal

    // random traffic: accept and hand-off in the same cycle under back-pressure
    for (int i = 0; i < 6000; i++) begin
      step(($urandom_range(0, 9) < 7), 8'($urandom), 8'($urandom),
           1'($urandom), 1'($urandom), 2'($urandom),
           ($urandom_range(0, 9) < 6), acc);
    end

    // drain
    for (int i = 0; i < 4; i++) step(1'b0, 8'h00, 8'h00, 0, 0, 2'b00, 1'b1, acc);
    check("R1", "all results delivered", q_exp.size(), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule